// File: doc/BRIEF.md
# Multi-bank GPIO port with set/clear data aliases

This block is a general-purpose I/O port built from several identical banks of up to 32 pins each. All banks share one 32-bit register bus and sit at fixed byte addresses. Each bank holds a direction word and an output latch. Software changes the latch in one of three ways: it writes the latch directly, it writes a set alias that turns on selected bits, or it writes a clear alias that turns off selected bits. Because of the aliases, software can change single pins without a read-modify-write.

On the pad side, the block drives an output level and an output enable for every pin. It samples every pad through a two-stage synchronizer, and a fifth word per bank shows the sampled level. That word reads the pin even when the block drives the pin, so software can read back what is on the wire.

The request side is a valid-only channel with no back-pressure: every beat with `req_valid` high is taken on that clock edge. A read beat returns its data on `rsp_rdata` with `rsp_valid` high exactly one clock later. The response channel has no ready signal, so the requester must accept the data in that cycle. A write beat produces no response.

Top module: `gpio_bank_port`

## Requirements
- R1: Bank b (0 to 4) occupies bytes 0x10 + 0x28*b up to 0x10 + 0x28*b + 0x27. Within a bank the words sit at these offsets: +0x00 direction, +0x04 output latch, +0x08 set alias, +0x0C clear alias, +0x10 input level. Address bits [1:0] are ignored.
- R2: After reset every direction bit is 1, the output latch is all zeros, and `pad_oe` is all zeros.
- R3: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output (`pad_oe` bit 1). `pad_out` always shows the output latch. Pin p of bank b is port bit 32*b + p.
- R4: A write to the set alias ORs the written ones into the latch; zero bits leave the latch unchanged. A read of the set alias returns the latch.
- R5: A write to the clear alias clears every latch bit written as 1; zero bits leave the latch unchanged. A read of the clear alias returns the latch.
- R6: A write to the output-latch word loads the latch directly, and a read returns it. On writes to direction, latch, set and clear, strobe bit k enables data bits 8k+7 down to 8k. Disabled bytes keep their old value, or are treated as zeros on the aliases.
- R7: The input word shows the synchronized pad level of every pin, including pins driven as outputs. After a pad change, reads taken on the first two clock edges still return the old level. The read taken on the third edge returns the new level.
- R8: Reads return zero at these addresses: below 0x10, beyond the last bank, and bank offsets +0x14 to +0x27. Writes to those addresses, and writes to the input word, change no state.
- R9: Each read beat gives `rsp_valid` high on the next cycle with its data. `rsp_valid` is low in the cycle after a write beat or after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the port and the synchronizer |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid, one cycle after the read beat |
| rsp_rdata | output | 32 | Read data (zero when no read response) |
| pad_in | input | NUM_BANKS*PINS | Pad levels, asynchronous |
| pad_out | output | NUM_BANKS*PINS | Output latch to pads |
| pad_oe | output | NUM_BANKS*PINS | Output enable to pads (1 = drive) |

## Verification
Register writes take effect on the accepting edge. The bench therefore checks `pad_out` and `pad_oe` at the falling edge right after a write beat, and reads taken on the next beat already see the new value. Read data is due one clock after the read beat, and the bench samples `rsp_rdata` at the falling edge that follows. For pad inputs, the bench holds `pad_in` still long enough to cover the two synchronizer stages before it sweeps reads. For R7, it issues back-to-back reads on the first three edges after a change and expects the old, old and new levels.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [3:0] {
    GW_DIR = 4'd0,
    GW_OUT = 4'd1,
    GW_SET = 4'd2,
    GW_CLR = 4'd3,
    GW_IN  = 4'd4
  } gpio_word_e;

  localparam int unsigned WORD_W = 32;

  function automatic logic [WORD_W-1:0] strb_to_mask(input logic [3:0] s);
    logic [WORD_W-1:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{s[k]}};
    return m;
  endfunction
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE      = 32'h10,
  parameter int unsigned STRIDE    = 32'h28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [3:0]           word,
  output logic                 mapped
);
  logic [3:0] word_b [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    localparam int unsigned LO = BASE + b * STRIDE;
    always_comb begin
      bank_sel[b] = (int'(addr) >= int'(LO)) && (int'(addr) < int'(LO + STRIDE));
      word_b[b]   = 4'((int'(addr) - int'(LO)) / 4);
    end
  end

  always_comb begin
    word = 4'd0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) word = word_b[b];
    mapped = (|bank_sel) && (word <= gpio_port_pkg::GW_IN);
  end

  a_r1_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] wmask,
  input  logic [PINS-1:0]  pad_in,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe,
  output logic [WORD_W-1:0] rd_word
);
  logic [PINS-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic [PINS-1:0] wd, wm;

  assign wd = wdata[PINS-1:0];
  assign wm = wmask[PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (wr_en) begin
      case (word)
        GW_DIR:  dir_q <= (dir_q & ~wm) | (wd & wm);
        GW_OUT:  lat_q <= (lat_q & ~wm) | (wd & wm);
        GW_SET:  lat_q <= lat_q | (wd & wm);
        GW_CLR:  lat_q <= lat_q & ~(wd & wm);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;

  always_comb begin
    rd_word = '0;
    case (word)
      GW_DIR:                 rd_word[PINS-1:0] = dir_q;
      GW_OUT, GW_SET, GW_CLR: rd_word[PINS-1:0] = lat_q;
      GW_IN:                  rd_word[PINS-1:0] = sync2_q;
      default:                rd_word = '0;
    endcase
  end

  a_r4_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == GW_SET) |=> ((pad_out & $past(pad_out)) == $past(pad_out)));
  a_r5_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == GW_CLR) |=> ((pad_out & ~$past(pad_out)) == '0));
  a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n)) |-> (sync2_q == $past(pad_in, 2)));
  a_r8_input_word_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == GW_IN) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned PINS      = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE      = 32'h10,
  parameter int unsigned STRIDE    = 32'h28
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [31:0]               req_wdata,
  input  logic [3:0]                req_strb,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  input  logic [NUM_BANKS*PINS-1:0] pad_in,
  output logic [NUM_BANKS*PINS-1:0] pad_out,
  output logic [NUM_BANKS*PINS-1:0] pad_oe
);
  logic [NUM_BANKS-1:0] bank_sel;
  logic [3:0]           word;
  logic                 mapped;
  logic [WORD_W-1:0]    wmask;
  logic [WORD_W-1:0]    rd_b [NUM_BANKS];
  logic [WORD_W-1:0]    rd_mux;

  gpio_port_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .addr(req_addr),
    .bank_sel(bank_sel), .word(word), .mapped(mapped)
  );

  assign wmask = strb_to_mask(req_strb);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_port_bank #(.PINS(PINS)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(req_valid && req_write && bank_sel[b]),
      .word(word), .wdata(req_wdata), .wmask(wmask),
      .pad_in(pad_in[b*PINS +: PINS]),
      .pad_out(pad_out[b*PINS +: PINS]),
      .pad_oe(pad_oe[b*PINS +: PINS]),
      .rd_word(rd_b[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b] && mapped) rd_mux = rd_mux | rd_b[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !mapped) |=> (rsp_rdata == 32'h0));
  a_r8_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !mapped) |=> ($stable(pad_out) && $stable(pad_oe)));
  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: tb/gpio_bank_port_tb_top.sv
module gpio_bank_port_tb_top;
  localparam int NB = 5;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_strb = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NB*NP-1:0] pad_in = '0, pad_out, pad_oe;

  always #10 clk = ~clk;

  gpio_bank_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [31:0] m_dir [NB];
  logic [31:0] m_lat [NB];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic logic [31:0] rnd_next(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] smask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] addr);
    int a, off, b, w;
    a = int'(addr) & 32'hFC;
    if (a < 16) return 32'h0;
    off = a - 16;
    b = off / 40;
    w = (off % 40) / 4;
    if (b >= NB) return 32'h0;
    case (w)
      0: return m_dir[b];
      1, 2, 3: return m_lat[b];
      4: return pad_in[b*NP +: NP];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NB*NP-1:0] got, input logic [NB*NP-1:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_pads(input string tag);
    logic [NB*NP-1:0] eo, ee;
    for (int b = 0; b < NB; b++) begin
      eo[b*NP +: NP] = m_lat[b];
      ee[b*NP +: NP] = ~m_dir[b];
    end
    chk({tag, " R3 pad_out"}, pad_out, eo);
    chk({tag, " R3 pad_oe"}, pad_oe, ee);
  endtask

  // issued right after a falling edge; returns after the next falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    int off, b, w;
    logic [31:0] m;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_strb = s;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk("R9 no response to write", {{(NB*NP-1){1'b0}}, rsp_valid}, '0);
    m = smask(s) & d;
    if ((int'(a) & 32'hFC) >= 16) begin
      off = (int'(a) & 32'hFC) - 16; b = off / 40; w = (off % 40) / 4;
      if (b < NB) begin
        case (w)
          0: m_dir[b] = (m_dir[b] & ~smask(s)) | m;
          1: m_lat[b] = (m_lat[b] & ~smask(s)) | m;
          2: m_lat[b] = m_lat[b] | m;
          3: m_lat[b] = m_lat[b] & ~m;
          default: ;
        endcase
      end
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R9 read response valid", {{(NB*NP-1){1'b0}}, rsp_valid}, {{(NB*NP-1){1'b0}}, 1'b1});
    d = rsp_rdata;
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d;
    for (int a = 0; a < 256; a += 4) begin
      bus_rd(8'(a + (a % 3)), d);
      chk($sformatf("%s R1 R8 read @%02h", tag, a), {{(NB*NP-32){1'b0}}, d},
          {{(NB*NP-32){1'b0}}, exp_rd(8'(a))});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, old;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_lat[b] = '0; end
    for (int b = 0; b < NB; b++) pad_in[b*NP +: NP] = 32'hA5C3_0000 ^ (32'h1111 * b);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_pads("R2 reset");
    sweep("R2 reset");

    // R4 / R5 / R6 directed on bank 2
    bus_wr(8'h10 + 8'd80 + 8'h4, 32'h0000_000F, 4'hF);
    bus_wr(8'h10 + 8'd80 + 8'h8, 32'h0000_00F0, 4'hF);
    chk_pads("R4 set");
    bus_rd(8'h10 + 8'd80 + 8'h8, d);
    chk("R4 set alias readback", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, 32'h0000_00FF});
    bus_wr(8'h10 + 8'd80 + 8'hC, 32'h0000_0011, 4'hF);
    bus_rd(8'h10 + 8'd80 + 8'hC, d);
    chk("R5 clear alias readback", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, 32'h0000_00EE});
    bus_wr(8'h10 + 8'd80 + 8'h4, 32'hDEAD_BEEF, 4'b0101);
    bus_rd(8'h10 + 8'd80 + 8'h4, d);
    chk("R6 strobed latch load", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, 32'h00AD_00EF});
    bus_wr(8'h10 + 8'd80, 32'h0000_0000, 4'b0010);
    chk_pads("R6 strobed dir");

    // R8 unmapped and read-only writes
    bus_wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    bus_wr(8'h10 + 8'h14, 32'hFFFF_FFFF, 4'hF);
    bus_wr(8'h10 + 8'h24, 32'hFFFF_FFFF, 4'hF);
    bus_wr(8'h10 + 8'h10, 32'hFFFF_FFFF, 4'hF);
    bus_wr(8'hD8, 32'hFFFF_FFFF, 4'hF);
    bus_wr(8'hFC, 32'h0, 4'hF);
    chk_pads("R8 ignored writes");
    sweep("R8 after ignored writes");

    // R7 input reads pin even when driven, and latency
    bus_wr(8'h10, 32'h0, 4'hF);
    bus_wr(8'h14, 32'h1234_5678, 4'hF);
    bus_rd(8'h20, d);
    chk("R7 input reads pad not latch", {{(NB*NP-32){1'b0}}, d},
        {{(NB*NP-32){1'b0}}, pad_in[31:0]});
    old = pad_in[NP +: NP];
    pad_in[NP +: NP] = ~old;
    bus_rd(8'h38 + 8'h10, d);
    chk("R7 edge1 old", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, old});
    bus_rd(8'h38 + 8'h10, d);
    chk("R7 edge2 old", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, old});
    bus_rd(8'h38 + 8'h10, d);
    chk("R7 edge3 new", {{(NB*NP-32){1'b0}}, d}, {{(NB*NP-32){1'b0}}, ~old});

    // pseudo-random sweep over banks, words, data and strobes
    for (int i = 0; i < 400; i++) begin
      int b, w;
      logic [7:0] a;
      lfsr = rnd_next(lfsr); b = int'(lfsr[7:0]) % 6;
      lfsr = rnd_next(lfsr); w = int'(lfsr[7:0]) % 10;
      a = (b < NB) ? 8'(16 + 40 * b + 4 * w) : 8'(lfsr[15:8] | 8'hE0);
      lfsr = rnd_next(lfsr); d = lfsr;
      lfsr = rnd_next(lfsr);
      bus_wr(a, d, lfsr[3:0]);
      chk_pads($sformatf("R4 R5 R6 random op %0d", i));
      if (i % 100 == 99) begin
        lfsr = rnd_next(lfsr);
        pad_in[(i / 100) * NP +: NP] = lfsr;
        repeat (3) @(negedge clk);
        sweep($sformatf("R7 random sweep %0d", i));
      end
    end

    req_valid = 0;
    @(negedge clk);
    chk("R9 idle gives no response", {{(NB*NP-1){1'b0}}, rsp_valid}, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule